// File: doc/BRIEF.md
# Dataflow Reorder Buffer with Wakeup

This block is a circular instruction window for an out-of-order core. A decoder writes renamed instructions into it one per cycle. Each slot holds an opcode, two source operands, a destination register and an exception cause. Each source operand is either a value that is already present or the tag of the slot that will produce it. A small rename table maps each architectural register to the youngest in-flight slot that writes it. A source with no valid mapping reads the architectural register file when it is allocated.

Functional units outside the block take at most one ready instruction per cycle from the dispatch port. They later broadcast a tag/result pair. Every slot still waiting on that tag captures the value, so dependent instructions wake up without any central scoreboard. Results are retired into the register file strictly in allocation order.

When the oldest slot has completed with a nonzero cause, the whole window is discarded. The allocate pointer snaps back to the commit pointer and every rename mapping is dropped, so that later instructions see only committed state.

The allocation port is valid/ready. `alloc_ready` does not depend on `alloc_valid`, and the decoder holds its fields steady while `alloc_valid` is high and `alloc_ready` is low. The dispatch port is also valid/ready. The offered instruction is always the oldest ready one, so the offer may change while it is not accepted, for example when an older slot wakes up. The completion bus and the commit and exception outputs have no back-pressure.

Top module: `dataflow_rob`

## Requirements
- R1: After reset the window is empty. `alloc_ready` is 1, `alloc_tag` is 0, and `disp_valid`, `commit_valid` and `exc_valid` are 0. Architectural register i holds RF_BASE + i.
- R2: An instruction is accepted in a cycle with `alloc_valid` and `alloc_ready` both high. `alloc_tag` gives the slot it takes, and successive tags count up by one modulo DEPTH.
- R3: At allocation, each source is resolved as follows. With no valid rename mapping, it takes the register file value and is present. With a mapping to a completed slot, it takes that slot's result and is present. Otherwise it keeps the mapped tag and waits.
- R4: A slot is offered on `disp_valid`/`disp_tag`, with its opcode and both operand values, only while it is occupied, not yet dispatched, and has both sources present. Once it is accepted (`disp_valid` and `disp_ready`), it is never offered again.
- R5: When several slots are ready, the one nearest the commit pointer (the oldest) is offered.
- R6: A broadcast (`cmp_valid`, `cmp_tag`, `cmp_data`) fills every waiting source whose tag equals `cmp_tag` and marks it present. It also marks the dispatched slot `cmp_tag` complete with result `cmp_data`.
- R7: A broadcast in the same cycle as an allocation is also captured by the sources of the instruction being allocated.
- R8: When the oldest slot is complete with cause 0, `commit_valid` pulses for one cycle with its destination and result. The register file is written and the commit pointer moves on. A younger completed slot never retires before an older one.
- R9: At commit, a rename mapping is released only if it still names the retiring slot. A newer writer of the same register keeps younger readers waiting on it.
- R10: With DEPTH slots occupied, `alloc_ready` is 0 and no instruction is accepted.
- R11: When the oldest slot is complete with a nonzero cause, `exc_valid` pulses with that cause and `alloc_ready` is 0 in that cycle. No register is written. All slots are discarded, the next `alloc_tag` equals the commit pointer, and all rename mappings are cleared, so later sources read the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_valid | input | 1 | Decoder offers an instruction |
| alloc_ready | output | 1 | Window can accept an instruction |
| alloc_op | input | OP_W | Opcode |
| alloc_src1 | input | REG_W | First source register |
| alloc_src2 | input | REG_W | Second source register |
| alloc_dst | input | REG_W | Destination register |
| alloc_cause | input | CAUSE_W | Exception cause, 0 for none |
| alloc_tag | output | log2(DEPTH) | Slot the next accepted instruction takes |
| disp_valid | output | 1 | A ready instruction is offered |
| disp_ready | input | 1 | Functional unit takes the offer |
| disp_tag | output | log2(DEPTH) | Slot of the offered instruction |
| disp_op | output | OP_W | Opcode of the offered instruction |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| cmp_valid | input | 1 | Result broadcast present |
| cmp_tag | input | log2(DEPTH) | Slot that produced the result |
| cmp_data | input | DATA_W | Result value |
| commit_valid | output | 1 | Oldest slot retires this cycle |
| commit_reg | output | REG_W | Register written by the retiring slot |
| commit_data | output | DATA_W | Value written |
| exc_valid | output | 1 | Oldest slot raises an exception, window flushed |
| exc_cause | output | CAUSE_W | Cause of the exception |

## Verification
The bench builds the window with DEPTH = 4, RF_BASE = 16, 8-bit data and 8 architectural registers. Four slots let a handful of allocations wrap the tags, fill the window and exercise the oldest-first pick across the wrap point. The 8-bit data makes a dependent chain overflow and wrap, so wakeup values are checked with numbers that differ from every initial register value. The distinct reset contents of the register file show whether a source was read from it or from an in-flight slot, which separates the rename, bypass and flush cases.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int DATA_W  = 8;
  localparam int REG_W   = 3;
  localparam int OP_W    = 4;
  localparam int CAUSE_W = 2;
  localparam int NREG    = 1 << REG_W;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [REG_W-1:0]  areg_t;

  // A source operand: value when present, producer tag (low bits) otherwise
  typedef struct packed {
    logic  ready;
    word_t val;
  } operand_t;

  typedef struct packed {
    logic                busy;
    logic                exec;
    logic [OP_W-1:0]     op;
    operand_t            src1;
    operand_t            src2;
    logic                done;
    areg_t               dst;
    word_t               result;
    logic [CAUSE_W-1:0]  cause;
  } slot_t;
endpackage

// File: rtl/rob_rename_table.sv
module rob_rename_table
  import rob_pkg::*;
#(
  parameter int TAG_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  areg_t [1:0]             look_reg,
  output logic  [1:0]             look_hit,
  output logic  [1:0][TAG_W-1:0]  look_tag,
  input  logic                    set_en,
  input  areg_t                   set_reg,
  input  logic  [TAG_W-1:0]       set_tag,
  input  logic                    rel_en,
  input  areg_t                   rel_reg,
  input  logic  [TAG_W-1:0]       rel_tag,
  input  logic                    flush
);
  logic [NREG-1:0]            map_v;
  logic [NREG-1:0][TAG_W-1:0] map_t;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_v <= '0;
      map_t <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (flush) begin
          map_v[r] <= 1'b0;
        end else if (set_en && set_reg == areg_t'(r)) begin
          map_v[r] <= 1'b1;
          map_t[r] <= set_tag;
        end else if (rel_en && rel_reg == areg_t'(r) && map_t[r] == rel_tag) begin
          map_v[r] <= 1'b0;
        end
      end
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_look
    assign look_hit[p] = map_v[look_reg[p]];
    assign look_tag[p] = map_t[look_reg[p]];
  end
endmodule

// File: rtl/rob_arch_regs.sv
module rob_arch_regs
  import rob_pkg::*;
#(
  parameter int RF_BASE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  areg_t [1:0]  rd_addr,
  output word_t [1:0]  rd_data,
  input  logic         wr_en,
  input  areg_t        wr_addr,
  input  word_t        wr_data
);
  word_t regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) regs_q[r] <= word_t'(RF_BASE + r);
    end else if (wr_en) begin
      regs_q[wr_addr] <= wr_data;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_rd
    assign rd_data[p] = regs_q[rd_addr[p]];
  end
endmodule

// File: rtl/rob_oldest_pick.sv
module rob_oldest_pick #(
  parameter  int DEPTH = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] cand,
  input  logic [TAG_W-1:0] base,
  output logic             any,
  output logic [TAG_W-1:0] pick
);
  // Scan youngest to oldest so the oldest candidate is written last
  always_comb begin
    any  = 1'b0;
    pick = base;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (cand[base + TAG_W'(k)]) begin
        any  = 1'b1;
        pick = base + TAG_W'(k);
      end
    end
  end
endmodule

// File: rtl/dataflow_rob.sv
module dataflow_rob
  import rob_pkg::*;
#(
  parameter  int DEPTH   = 4,   // power of two, at least 2
  parameter  int RF_BASE = 16,
  localparam int TAG_W   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  output logic               alloc_ready,
  input  logic [OP_W-1:0]    alloc_op,
  input  logic [REG_W-1:0]   alloc_src1,
  input  logic [REG_W-1:0]   alloc_src2,
  input  logic [REG_W-1:0]   alloc_dst,
  input  logic [CAUSE_W-1:0] alloc_cause,
  output logic [TAG_W-1:0]   alloc_tag,
  output logic               disp_valid,
  input  logic               disp_ready,
  output logic [TAG_W-1:0]   disp_tag,
  output logic [OP_W-1:0]    disp_op,
  output logic [DATA_W-1:0]  disp_a,
  output logic [DATA_W-1:0]  disp_b,
  input  logic               cmp_valid,
  input  logic [TAG_W-1:0]   cmp_tag,
  input  logic [DATA_W-1:0]  cmp_data,
  output logic               commit_valid,
  output logic [REG_W-1:0]   commit_reg,
  output logic [DATA_W-1:0]  commit_data,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause
);
  localparam int CNT_W = TAG_W + 1;

  slot_t            slot_q [DEPTH];
  logic [TAG_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  logic head_done, commit_fire, exc_fire, alloc_fire, disp_fire;
  areg_t    [1:0]            src_reg;
  logic     [1:0]            map_hit;
  logic     [1:0][TAG_W-1:0] map_tag;
  word_t    [1:0]            rf_val;
  operand_t [1:0]            src_res;
  logic [DEPTH-1:0]          cand;
  slot_t                     new_slot;

  // Retirement decision on the oldest slot
  assign head_done   = slot_q[head_q].busy && slot_q[head_q].done;
  assign commit_fire = head_done && (slot_q[head_q].cause == '0);
  assign exc_fire    = head_done && (slot_q[head_q].cause != '0);

  assign alloc_ready = (count_q != CNT_W'(DEPTH)) && !exc_fire;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_q;

  assign commit_valid = commit_fire;
  assign commit_reg   = slot_q[head_q].dst;
  assign commit_data  = slot_q[head_q].result;
  assign exc_valid    = exc_fire;
  assign exc_cause    = slot_q[head_q].cause;

  assign src_reg[0] = alloc_src1;
  assign src_reg[1] = alloc_src2;

  rob_rename_table #(.TAG_W(TAG_W)) u_rename (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_reg (src_reg),
    .look_hit (map_hit),
    .look_tag (map_tag),
    .set_en   (alloc_fire),
    .set_reg  (alloc_dst),
    .set_tag  (tail_q),
    .rel_en   (commit_fire),
    .rel_reg  (slot_q[head_q].dst),
    .rel_tag  (head_q),
    .flush    (exc_fire)
  );

  rob_arch_regs #(.RF_BASE(RF_BASE)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_addr (src_reg),
    .rd_data (rf_val),
    .wr_en   (commit_fire),
    .wr_addr (slot_q[head_q].dst),
    .wr_data (slot_q[head_q].result)
  );

  // Source resolution: register file, completed producer, same-cycle bus, or tag
  always_comb begin
    for (int p = 0; p < 2; p++) begin
      src_res[p].ready = 1'b1;
      src_res[p].val   = rf_val[p];
      if (map_hit[p]) begin
        if (slot_q[map_tag[p]].done) begin
          src_res[p].val = slot_q[map_tag[p]].result;
        end else if (cmp_valid && cmp_tag == map_tag[p]) begin
          src_res[p].val = cmp_data;
        end else begin
          src_res[p].ready = 1'b0;
          src_res[p].val   = word_t'(map_tag[p]);
        end
      end
    end
  end

  always_comb begin
    new_slot        = '0;
    new_slot.busy   = 1'b1;
    new_slot.op     = alloc_op;
    new_slot.src1   = src_res[0];
    new_slot.src2   = src_res[1];
    new_slot.dst    = alloc_dst;
    new_slot.cause  = alloc_cause;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_cand
    assign cand[i] = slot_q[i].busy && !slot_q[i].exec &&
                     slot_q[i].src1.ready && slot_q[i].src2.ready;
  end

  rob_oldest_pick #(.DEPTH(DEPTH)) u_pick (
    .cand (cand),
    .base (head_q),
    .any  (disp_valid),
    .pick (disp_tag)
  );

  assign disp_op   = slot_q[disp_tag].op;
  assign disp_a    = slot_q[disp_tag].src1.val;
  assign disp_b    = slot_q[disp_tag].src2.val;
  assign disp_fire = disp_valid && disp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (cmp_valid && slot_q[i].busy) begin
          if (!slot_q[i].src1.ready && slot_q[i].src1.val[TAG_W-1:0] == cmp_tag) begin
            slot_q[i].src1.ready <= 1'b1;
            slot_q[i].src1.val   <= cmp_data;
          end
          if (!slot_q[i].src2.ready && slot_q[i].src2.val[TAG_W-1:0] == cmp_tag) begin
            slot_q[i].src2.ready <= 1'b1;
            slot_q[i].src2.val   <= cmp_data;
          end
          if (slot_q[i].exec && !slot_q[i].done && TAG_W'(i) == cmp_tag) begin
            slot_q[i].done   <= 1'b1;
            slot_q[i].result <= cmp_data;
          end
        end
      end
      if (disp_fire) slot_q[disp_tag].exec <= 1'b1;
      if (commit_fire) begin
        slot_q[head_q].busy <= 1'b0;
        head_q              <= head_q + 1'b1;
      end
      if (alloc_fire) begin
        slot_q[tail_q] <= new_slot;
        tail_q         <= tail_q + 1'b1;
      end
      if (exc_fire) begin
        for (int i = 0; i < DEPTH; i++) slot_q[i].busy <= 1'b0;
        tail_q  <= head_q;
        count_q <= '0;
      end else begin
        count_q <= count_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
      end
    end
  end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
  parameter  int DEPTH = 4,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [TAG_W-1:0] alloc_tag,
  input logic             disp_valid,
  input logic             disp_ready,
  input logic [TAG_W-1:0] disp_tag,
  input logic             commit_valid,
  input logic             exc_valid,
  input logic [TAG_W-1:0] head
);
  logic [TAG_W:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         occ <= '0;
    else if (exc_valid) occ <= '0;
    else                occ <= occ + (TAG_W+1)'(alloc_valid && alloc_ready)
                                   - (TAG_W+1)'(commit_valid);
  end

  assert_alloc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> (alloc_tag == $past(alloc_tag) + 1'b1));

  assert_no_redispatch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready) |=> !(disp_valid && disp_tag == $past(disp_tag)));

  assert_commit_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit_valid |=> (head == $past(head) + 1'b1));

  assert_full_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == (TAG_W+1)'(DEPTH)) |-> !alloc_ready);

  assert_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> (alloc_tag == $past(head)) && !disp_valid && !commit_valid);
endmodule

bind dataflow_rob rob_checker #(.DEPTH(DEPTH)) u_rob_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .alloc_valid  (alloc_valid),
  .alloc_ready  (alloc_ready),
  .alloc_tag    (alloc_tag),
  .disp_valid   (disp_valid),
  .disp_ready   (disp_ready),
  .disp_tag     (disp_tag),
  .commit_valid (commit_valid),
  .exc_valid    (exc_valid),
  .head         (head_q)
);

// File: tb/dataflow_rob_tb_top.sv
module dataflow_rob_tb_top;
  import rob_pkg::*;

  localparam int DEPTH   = 4;
  localparam int TAG_W   = 2;
  localparam int RF_BASE = 16;

  // Each vector: {src1, src2, dst, expected result of src1 + src2}
  localparam logic [16:0] VEC [6] = '{
    {3'd2, 3'd3, 3'd1, 8'd37},
    {3'd1, 3'd1, 3'd4, 8'd74},
    {3'd4, 3'd7, 3'd0, 8'd97},
    {3'd0, 3'd0, 3'd7, 8'd194},
    {3'd7, 3'd1, 3'd2, 8'd231},
    {3'd2, 3'd3, 3'd5, 8'd250}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic               rst_n = 1'b0;
  logic               alloc_valid = 1'b0, alloc_ready;
  logic [OP_W-1:0]    alloc_op = '0;
  logic [REG_W-1:0]   alloc_src1 = '0, alloc_src2 = '0, alloc_dst = '0;
  logic [CAUSE_W-1:0] alloc_cause = '0;
  logic [TAG_W-1:0]   alloc_tag;
  logic               disp_valid, disp_ready = 1'b0;
  logic [TAG_W-1:0]   disp_tag;
  logic [OP_W-1:0]    disp_op;
  logic [DATA_W-1:0]  disp_a, disp_b;
  logic               cmp_valid = 1'b0;
  logic [TAG_W-1:0]   cmp_tag = '0;
  logic [DATA_W-1:0]  cmp_data = '0;
  logic               commit_valid, exc_valid;
  logic [REG_W-1:0]   commit_reg;
  logic [DATA_W-1:0]  commit_data;
  logic [CAUSE_W-1:0] exc_cause;

  dataflow_rob #(.DEPTH(DEPTH), .RF_BASE(RF_BASE)) dut_i (.*);

  int checks = 0, errors = 0, cyc = 0;
  int log_n = 0, seen = 0;
  logic [2:0] log_reg [64];
  logic [7:0] log_dat [64];
  logic [7:0] m [8];

  always @(negedge clk)
    if (rst_n && commit_valid && log_n < 64) begin
      log_reg[log_n] = commit_reg;
      log_dat[log_n] = commit_data;
      log_n = log_n + 1;
    end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_alloc(input logic [2:0] s1, input logic [2:0] s2, input logic [2:0] d,
                          input logic [1:0] cs, output logic [1:0] tag);
    alloc_valid = 1'b1; alloc_op = 4'h3;
    alloc_src1 = s1; alloc_src2 = s2; alloc_dst = d; alloc_cause = cs;
    while (!alloc_ready) @(negedge clk);
    tag = alloc_tag;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_disp(output bit ok, output logic [1:0] tag,
                         output logic [7:0] a, output logic [7:0] b);
    ok = disp_valid; tag = disp_tag; a = disp_a; b = disp_b;
    if (ok) begin
      disp_ready = 1'b1;
      @(negedge clk);
      disp_ready = 1'b0;
    end
  endtask

  task automatic do_cmp(input logic [1:0] tag, input logic [7:0] d);
    cmp_valid = 1'b1; cmp_tag = tag; cmp_data = d;
    @(negedge clk);
    cmp_valid = 1'b0;
  endtask

  task automatic expect_commit(input string req, input logic [2:0] r, input logic [7:0] d);
    check(req, "commit present", int'(log_n > seen), 1);
    if (log_n > seen) begin
      check(req, "commit reg", int'(log_reg[seen]), int'(r));
      check(req, "commit data", int'(log_dat[seen]), int'(d));
      seen++;
    end
    m[r] = d;
  endtask

  initial begin
    bit ok;
    logic [1:0] t0, t1, t2, dt;
    logic [7:0] a, b, x, y;
    logic [1:0] ft [4];
    logic [7:0] fr [4];
    int exp_tail = 0;

    for (int r = 0; r < 8; r++) m[r] = 8'(RF_BASE + r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1", "alloc_ready", int'(alloc_ready), 1);
    check("R1", "alloc_tag", int'(alloc_tag), 0);
    check("R1", "disp_valid", int'(disp_valid), 0);
    check("R1", "commit_valid", int'(commit_valid), 0);
    check("R1", "exc_valid", int'(exc_valid), 0);

    // Vector walk: one instruction at a time through every stage
    for (int i = 0; i < 6; i++) begin
      logic [2:0] s1, s2, d;
      logic [7:0] e;
      {s1, s2, d, e} = VEC[i];
      do_alloc(s1, s2, d, 2'd0, t0);
      check("R2", "alloc tag", int'(t0), exp_tail % DEPTH);
      exp_tail++;
      do_disp(ok, dt, a, b);
      check("R4", "offered", int'(ok), 1);
      check("R4", "disp tag", int'(dt), int'(t0));
      check("R4", "disp op", int'(disp_op), 3);
      check("R3", "operand a", int'(a), int'(m[s1]));
      check("R3", "operand b", int'(b), int'(m[s2]));
      do_cmp(dt, a + b);
      @(negedge clk);
      expect_commit("R8", d, e);
    end

    // R4/R6: dependent chain wakes on broadcast
    do_alloc(3'd1, 3'd2, 3'd6, 2'd0, t0);
    do_alloc(3'd6, 3'd6, 3'd3, 2'd0, t1);
    do_disp(ok, dt, a, b);
    check("R4", "producer offered", int'(dt), int'(t0));
    check("R4", "consumer waits", int'(disp_valid), 0);
    x = a + b;
    do_cmp(t0, x);
    check("R6", "consumer woken", int'(disp_valid), 1);
    check("R6", "consumer tag", int'(disp_tag), int'(t1));
    check("R6", "woken a", int'(disp_a), int'(x));
    check("R6", "woken b", int'(disp_b), int'(x));
    do_disp(ok, dt, a, b);
    do_cmp(t1, a + b);
    @(negedge clk);
    expect_commit("R6", 3'd6, x);
    expect_commit("R6", 3'd3, 8'(x + x));

    // R5/R8: oldest first, younger completion waits for older
    do_alloc(3'd2, 3'd2, 3'd1, 2'd0, t0);
    do_alloc(3'd3, 3'd3, 3'd2, 2'd0, t1);
    check("R5", "oldest offered", int'(disp_tag), int'(t0));
    do_disp(ok, dt, a, b);
    x = a + b;
    do_disp(ok, dt, a, b);
    check("R5", "second offered", int'(dt), int'(t1));
    y = a + b;
    do_cmp(t1, y);
    check("R8", "younger held", int'(commit_valid), 0);
    do_cmp(t0, x);
    @(negedge clk);
    @(negedge clk);
    expect_commit("R8", 3'd1, x);
    expect_commit("R8", 3'd2, y);

    // R10: full window stalls allocation
    for (int k = 0; k < 4; k++) do_alloc(3'd0, 3'd0, 3'(4 + k), 2'd0, ft[k]);
    check("R10", "ready when full", int'(alloc_ready), 0);
    alloc_valid = 1'b1; alloc_dst = 3'd0;
    repeat (2) @(negedge clk);
    check("R10", "still stalled", int'(alloc_ready), 0);
    check("R10", "tag held", int'(alloc_tag), int'(ft[0]));
    alloc_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      do_disp(ok, dt, a, b);
      check("R10", "drain order", int'(dt), int'(ft[k]));
      fr[k] = a + b;
      do_cmp(dt, fr[k]);
    end
    @(negedge clk);
    for (int k = 0; k < 4; k++) expect_commit("R10", 3'(4 + k), fr[k]);

    // R7: broadcast seen by the instruction allocated in the same cycle
    do_alloc(3'd5, 3'd5, 3'd4, 2'd0, t0);
    do_disp(ok, dt, a, b);
    x = a + b;
    cmp_valid = 1'b1; cmp_tag = t0; cmp_data = x;
    alloc_valid = 1'b1; alloc_src1 = 3'd4; alloc_src2 = 3'd0; alloc_dst = 3'd6; alloc_cause = '0;
    check("R7", "ready with bus", int'(alloc_ready), 1);
    t1 = alloc_tag;
    @(negedge clk);
    cmp_valid = 1'b0; alloc_valid = 1'b0;
    check("R7", "bypass ready", int'(disp_valid), 1);
    check("R7", "bypass a", int'(disp_a), int'(x));
    check("R7", "plain b", int'(disp_b), int'(m[0]));
    do_disp(ok, dt, a, b);
    y = a + b;
    do_cmp(t1, y);
    @(negedge clk);
    expect_commit("R7", 3'd4, x);
    expect_commit("R7", 3'd6, y);

    // R9: mapping kept when a newer writer exists
    do_alloc(3'd2, 3'd2, 3'd1, 2'd0, t0);
    do_alloc(3'd3, 3'd3, 3'd1, 2'd0, t1);
    do_disp(ok, dt, a, b);
    x = a + b;
    do_disp(ok, dt, a, b);
    y = a + b;
    do_cmp(t0, x);
    @(negedge clk);
    do_alloc(3'd1, 3'd1, 3'd2, 2'd0, t2);
    check("R9", "reader waits on newer", int'(disp_valid), 0);
    do_cmp(t1, y);
    check("R9", "reader woken a", int'(disp_a), int'(y));
    check("R9", "reader tag", int'(disp_tag), int'(t2));
    do_disp(ok, dt, a, b);
    do_cmp(t2, a + b);
    @(negedge clk);
    expect_commit("R9", 3'd1, x);
    expect_commit("R9", 3'd1, y);
    expect_commit("R9", 3'd2, 8'(y + y));

    // R11: exception at the commit point flushes the window
    do_alloc(3'd0, 3'd0, 3'd2, 2'd1, t0);
    do_alloc(3'd2, 3'd2, 3'd5, 2'd0, t1);
    do_disp(ok, dt, a, b);
    do_cmp(t0, 8'd99);
    check("R11", "exc_valid", int'(exc_valid), 1);
    check("R11", "exc_cause", int'(exc_cause), 1);
    check("R11", "no commit", int'(commit_valid), 0);
    check("R11", "alloc blocked", int'(alloc_ready), 0);
    @(negedge clk);
    check("R11", "tag reset", int'(alloc_tag), int'(t0));
    check("R11", "younger discarded", int'(disp_valid), 0);
    check("R11", "ready again", int'(alloc_ready), 1);
    do_alloc(3'd2, 3'd5, 3'd7, 2'd0, t2);
    do_disp(ok, dt, a, b);
    check("R11", "operand a from regs", int'(a), int'(m[2]));
    check("R11", "operand b from regs", int'(b), int'(m[5]));
    x = a + b;
    do_cmp(dt, x);
    @(negedge clk);
    expect_commit("R11", 3'd7, x);
    check("R11", "no extra commits", log_n, seen);

    summary();
  end
endmodule